// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Interrupt Detection

This block controls a bank of general-purpose pins through a small word-addressed register interface. Software sets the direction of each pin. It changes output levels either by loading the whole output latch, or through two write-only ports that only raise or only lower the pins whose bits are 1. It reads back input levels after they pass through a synchroniser. Every register holds one bit per pin.

Each pin can raise an interrupt. A pin in level mode triggers while its synchronised input matches a programmed polarity. A pin in edge mode triggers on a rising edge, a falling edge or both, each under its own enable bit. Detected events are held in a per-pin pending flag. Two gates decide whether a pending flag is visible: a mask bit, which must be 0, and an enable bit, which must be 1. The visible flags appear in a status register. Software clears flags by writing 1s to a clear register, and the single interrupt output is the OR of all visible flags.

The bus is a simple single-cycle port. A write takes effect at the clock edge on which `busSel` and `busWrite` are both high. Read data is combinational from `busAddr` while `busSel` is high and `busWrite` is low.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, and `pinOut`, `pinOe` and `irqOut` are 0.
- R2: The direction register at byte address 0x00 reads back as written, and each 1 bit drives the matching `pinOe` bit high, meaning the pin is an output.
- R3: The output latch drives `pinOut` and reads at 0x20, and a write to 0x20 loads it whole. A write to 0x18 sets the latch bits where the data has 1s. A write to 0x1C clears the latch bits where the data has 1s. Zero bits in either write leave the latch unchanged.
- R4: Address 0x14 returns `pinIn` through a two-flop synchroniser: a pin change set up before clock edge k reads back after edge k+1.
- R5: Level mode is selected by a 1 at 0x04. The polarity bit at 0x08 picks active-high (1) or active-low (0). While the active level lasts, the pending flag is set again on every cycle, so a clear does not remove it.
- R6: Edge mode is selected by a 0 at 0x04. Bit i of 0x0C arms rising edges and bit i of 0x10 arms falling edges, and each works on its own. An edge is detected two edges after the pin changes, and it sets a flag that stays until it is cleared.
- R7: The status register at 0x30 shows pending flags ANDed with the inverse of the mask at 0x28 and with the enable at 0x2C.
- R8: Writing to 0x34 clears the pending flags where the data has 1s and leaves the others alone. A new event in the same cycle as a clear wins over the clear.
- R9: `irqOut` is high exactly when the status value is nonzero.
- R10: Reads of 0x18, 0x1C, unused or unaligned addresses return 0. Writes to 0x14 and 0x30 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 16 | Write data, one bit per pin |
| busRdata | output | 16 | Read data, combinational |
| pinIn | input | 16 | Asynchronous pin input levels |
| pinOut | output | 16 | Output latch driven to the pins |
| pinOe | output | 16 | Output enable per pin |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume that at most one register write happens per cycle and that `busWdata` and `busAddr` are stable at the clock edge. Under these conditions, a cycle after a write to direction, set, clear or the ignored registers has a single known effect. The bench drives every bus signal and pin on the falling clock edge, so each value is settled before the rising edge that samples it. Pin inputs may change every cycle. This exercises back-to-back edges through the synchroniser without breaking any of the assumptions above.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_DIR     = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LVL_SEL = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_LVL_POL = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_POS_EN  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_NEG_EN  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_DIN     = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_SET     = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR     = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DOUT    = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_ENA     = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_ICLR    = 6'h34;

  // Write strobes from the decoder to the datapath
  typedef struct packed {
    logic wrDir;
    logic wrLvlSel;
    logic wrLvlPol;
    logic wrPosEn;
    logic wrNegEn;
    logic wrSetOut;
    logic wrClrOut;
    logic wrOutData;
    logic wrMask;
    logic wrEnable;
    logic wrIntClr;
  } ctrlStrobes_t;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DIR, RD_LSEL, RD_LPOL, RD_PEN, RD_NEN,
    RD_DIN, RD_DOUT, RD_MASK, RD_ENA, RD_STAT
  } rdSel_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes,
  output rdSel_t            rdSel
);

  logic wrAct;
  logic rdAct;

  assign wrAct = busSel & busWrite;
  assign rdAct = busSel & ~busWrite;

  always_comb begin
    strobes = '0;
    rdSel   = RD_ZERO;
    case (busAddr)
      OFS_DIR:     begin strobes.wrDir     = wrAct; if (rdAct) rdSel = RD_DIR;  end
      OFS_LVL_SEL: begin strobes.wrLvlSel  = wrAct; if (rdAct) rdSel = RD_LSEL; end
      OFS_LVL_POL: begin strobes.wrLvlPol  = wrAct; if (rdAct) rdSel = RD_LPOL; end
      OFS_POS_EN:  begin strobes.wrPosEn   = wrAct; if (rdAct) rdSel = RD_PEN;  end
      OFS_NEG_EN:  begin strobes.wrNegEn   = wrAct; if (rdAct) rdSel = RD_NEN;  end
      OFS_DIN:     begin if (rdAct) rdSel = RD_DIN; end
      OFS_SET:     begin strobes.wrSetOut  = wrAct; end
      OFS_CLR:     begin strobes.wrClrOut  = wrAct; end
      OFS_DOUT:    begin strobes.wrOutData = wrAct; if (rdAct) rdSel = RD_DOUT; end
      OFS_MASK:    begin strobes.wrMask    = wrAct; if (rdAct) rdSel = RD_MASK; end
      OFS_ENA:     begin strobes.wrEnable  = wrAct; if (rdAct) rdSel = RD_ENA;  end
      OFS_STAT:    begin if (rdAct) rdSel = RD_STAT; end
      OFS_ICLR:    begin strobes.wrIntClr  = wrAct; end
      default:     begin end
    endcase
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= g_stg[s-1].q;
      end
    end
  end

  assign dout = g_stg[STAGES-1].q;

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  rdSel_t           rdSel,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irqOut
);

  logic [NPINS-1:0] dirQ, lvlSelQ, lvlPolQ, posEnQ, negEnQ;
  logic [NPINS-1:0] outQ, maskQ, enQ;
  logic [NPINS-1:0] syncIn, prevIn;
  logic [NPINS-1:0] pendQ, statusW, clrBits;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (syncIn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ    <= '0;
      lvlSelQ <= '0;
      lvlPolQ <= '0;
      posEnQ  <= '0;
      negEnQ  <= '0;
      outQ    <= '0;
      maskQ   <= '0;
      enQ     <= '0;
      prevIn  <= '0;
    end else begin
      prevIn <= syncIn;
      if (strobes.wrDir)     dirQ    <= wdata;
      if (strobes.wrLvlSel)  lvlSelQ <= wdata;
      if (strobes.wrLvlPol)  lvlPolQ <= wdata;
      if (strobes.wrPosEn)   posEnQ  <= wdata;
      if (strobes.wrNegEn)   negEnQ  <= wdata;
      if (strobes.wrMask)    maskQ   <= wdata;
      if (strobes.wrEnable)  enQ     <= wdata;
      if (strobes.wrOutData)     outQ <= wdata;
      else if (strobes.wrSetOut) outQ <= outQ | wdata;
      else if (strobes.wrClrOut) outQ <= outQ & ~wdata;
    end
  end

  assign clrBits = strobes.wrIntClr ? wdata : '0;

  // Per-pin event detection and sticky pending flag
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic lvlHit, riseHit, fallHit, evt;
    assign lvlHit  = lvlSelQ[i] & (syncIn[i] == lvlPolQ[i]);
    assign riseHit = posEnQ[i] & syncIn[i] & ~prevIn[i];
    assign fallHit = negEnQ[i] & ~syncIn[i] & prevIn[i];
    assign evt     = lvlHit | (~lvlSelQ[i] & (riseHit | fallHit));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ[i] <= 1'b0;
      else       pendQ[i] <= (pendQ[i] & ~clrBits[i]) | evt;
    end
  end

  assign statusW = pendQ & ~maskQ & enQ;
  assign irqOut  = |statusW;
  assign pinOut  = outQ;
  assign pinOe   = dirQ;

  always_comb begin
    case (rdSel)
      RD_DIR:  rdata = dirQ;
      RD_LSEL: rdata = lvlSelQ;
      RD_LPOL: rdata = lvlPolQ;
      RD_PEN:  rdata = posEnQ;
      RD_NEN:  rdata = negEnQ;
      RD_DIN:  rdata = syncIn;
      RD_DOUT: rdata = outQ;
      RD_MASK: rdata = maskQ;
      RD_ENA:  rdata = enQ;
      RD_STAT: rdata = statusW;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  output logic              irqOut
);

  ctrlStrobes_t strobes;
  rdSel_t       rdSel;

  gpio_ctrl u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes),
    .rdSel    (rdSel)
  );

  gpio_datapath #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wdata   (busWdata),
    .pinIn   (pinIn),
    .rdata   (busRdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [NPINS-1:0]  busWdata,
  input logic [NPINS-1:0]  pinOut,
  input logic [NPINS-1:0]  pinOe,
  input logic              irqOut
);

  logic wrAct;
  assign wrAct = busSel && busWrite;

  p_dir_drives_oe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && busAddr == OFS_DIR) |=> (pinOe == $past(busWdata)));

  p_set_raises_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && busAddr == OFS_SET) |=> ((pinOut & $past(busWdata)) == $past(busWdata)));

  p_clr_lowers_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && busAddr == OFS_CLR) |=> ((pinOut & $past(busWdata)) == '0));

  p_set_keeps_zero_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && busAddr == OFS_SET) |=> ((pinOut & ~$past(busWdata)) == ($past(pinOut) & ~$past(busWdata))));

  p_enable_off_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && busAddr == OFS_ENA && busWdata == '0) |=> !irqOut);

  p_mask_all_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && busAddr == OFS_MASK && busWdata == '1) |=> !irqOut);

  p_ro_write_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && (busAddr == OFS_DIN || busAddr == OFS_STAT)) |=> ($stable(pinOut) && $stable(pinOe)));

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .irqOut   (irqOut)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut, pinOe;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // Behavioural reference model
  logic [15:0] mDir, mLs, mLp, mPe, mNe, mOut, mMask, mEn, mPend;
  logic [15:0] mS1, mS2, mPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDir = 0; mLs = 0; mLp = 0; mPe = 0; mNe = 0; mOut = 0;
      mMask = 0; mEn = 0; mPend = 0; mS1 = 0; mS2 = 0; mPrev = 0;
    end else begin
      logic [15:0] evt, clrB;
      evt = 0;
      for (int i = 0; i < 16; i++) begin
        if (mLs[i]) evt[i] = (mS2[i] == mLp[i]);
        else evt[i] = (mPe[i] && mS2[i] && !mPrev[i]) || (mNe[i] && !mS2[i] && mPrev[i]);
      end
      clrB = (busSel && busWrite && busAddr == 6'h34) ? busWdata : 16'h0;
      mPend = (mPend & ~clrB) | evt;
      if (busSel && busWrite) begin
        case (busAddr)
          6'h00: mDir = busWdata;
          6'h04: mLs = busWdata;
          6'h08: mLp = busWdata;
          6'h0C: mPe = busWdata;
          6'h10: mNe = busWdata;
          6'h18: mOut = mOut | busWdata;
          6'h1C: mOut = mOut & ~busWdata;
          6'h20: mOut = busWdata;
          6'h28: mMask = busWdata;
          6'h2C: mEn = busWdata;
          default: ;
        endcase
      end
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    end
  end

  function automatic logic [15:0] modelRead(input logic [5:0] a);
    case (a)
      6'h00: return mDir;
      6'h04: return mLs;
      6'h08: return mLp;
      6'h0C: return mPe;
      6'h10: return mNe;
      6'h14: return mS2;
      6'h20: return mOut;
      6'h28: return mMask;
      6'h2C: return mEn;
      6'h30: return mPend & ~mMask & mEn;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Every-cycle port comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 pinOe", pinOe, mDir);
      chk("R3 pinOut", pinOut, mOut);
      chk("R9 irqOut", {15'h0, irqOut}, {15'h0, |(mPend & ~mMask & mEn)});
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag, output logic [15:0] v);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1;
    v = busRdata;
    chk(tag, busRdata, modelRead(a));
    busSel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic [15:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rstN = 1;
    // R1 reset state
    chk("R1 pinOut", pinOut, 16'h0);
    chk("R1 pinOe", pinOe, 16'h0);
    chk("R1 irqOut", {15'h0, irqOut}, 16'h0);
    for (int a = 0; a <= 'h34; a += 4) begin
      rd(a[5:0], "R1 register reset", v);
      chk("R1 reads zero", v, 16'h0);
    end
    // R2 direction
    wr(6'h00, 16'h00FF);
    rd(6'h00, "R2 direction readback", v);
    chk("R2 literal", pinOe, 16'h00FF);
    // R3 set / clear / load
    wr(6'h18, 16'h0F0F);
    wr(6'h1C, 16'h0003);
    rd(6'h20, "R3 latch readback", v);
    chk("R3 literal", v, 16'h0F0C);
    rd(6'h18, "R10 set reads zero", v);
    rd(6'h1C, "R10 clear reads zero", v);
    wr(6'h20, 16'hA5A5);
    rd(6'h20, "R3 load", v);
    // R10 read-only writes and odd addresses
    wr(6'h14, 16'hFFFF);
    wr(6'h30, 16'hFFFF);
    rd(6'h20, "R10 latch untouched", v);
    rd(6'h00, "R10 dir untouched", v);
    rd(6'h24, "R10 hole reads zero", v);
    rd(6'h3C, "R10 hole reads zero", v);
    rd(6'h01, "R10 unaligned reads zero", v);
    // R4 synchroniser latency
    pins(16'h1234);
    rd(6'h14, "R4 one cycle later", v);
    chk("R4 not yet visible", v, 16'h0000);
    rd(6'h14, "R4 two cycles later", v);
    chk("R4 literal", v, 16'h1234);
    pins(16'h0000);
    idle(3);
    // R6 edges: bit0 rising, bit1 falling, bit2 both
    wr(6'h28, 16'h0000);
    wr(6'h2C, 16'hFFFF);
    wr(6'h0C, 16'h0005);
    wr(6'h10, 16'h0006);
    pins(16'h0007);
    idle(3);
    rd(6'h30, "R6 rising", v);
    chk("R6 literal rise", v, 16'h0005);
    pins(16'h0000);
    idle(3);
    rd(6'h30, "R6 falling sticky", v);
    chk("R6 literal all", v, 16'h0007);
    // R8 partial clear then full clear
    wr(6'h34, 16'h0001);
    rd(6'h30, "R8 partial clear", v);
    chk("R8 literal", v, 16'h0006);
    wr(6'h34, v);
    rd(6'h30, "R8 cleared", v);
    chk("R9 irq low", {15'h0, irqOut}, 16'h0);
    // R5 level modes: bit4 high-active, bit5 low-active
    wr(6'h08, 16'h0010);
    wr(6'h04, 16'h0030);
    idle(1);
    rd(6'h30, "R5 low-active pin low", v);
    chk("R5 literal low", v, 16'h0020);
    pins(16'h0030);
    idle(3);
    rd(6'h30, "R5 high-active", v);
    wr(6'h34, 16'hFFFF);
    rd(6'h30, "R5 persists after clear", v);
    chk("R5 literal persist", v, 16'h0010);
    pins(16'h0020);
    idle(3);
    wr(6'h34, 16'hFFFF);
    rd(6'h30, "R5 gone when level drops", v);
    wr(6'h04, 16'h0000);
    wr(6'h34, 16'hFFFF);
    // R7 gating
    pins(16'h0000);
    idle(3);
    wr(6'h34, 16'hFFFF);
    wr(6'h28, 16'h0001);
    pins(16'h0001);
    idle(3);
    rd(6'h30, "R7 masked hidden", v);
    chk("R7 masked literal", v, 16'h0000);
    wr(6'h28, 16'h0000);
    rd(6'h30, "R7 unmasked shows", v);
    chk("R7 unmask literal", v, 16'h0001);
    wr(6'h2C, 16'h0000);
    rd(6'h30, "R7 disabled hidden", v);
    wr(6'h2C, 16'hFFFF);
    wr(6'h34, 16'hFFFF);
    // Mixed random run
    wr(6'h04, 16'h0F00);
    wr(6'h08, 16'h0300);
    wr(6'h0C, 16'h00F3);
    wr(6'h10, 16'hF0F5);
    wr(6'h28, 16'h1111);
    for (int n = 0; n < 300; n++) begin
      pins($urandom());
      if (n % 7 == 0) begin
        rd(6'h30, "R8 random status", v);
        wr(6'h34, v & 16'h5FFF);
      end
      if (n % 11 == 0) wr(6'h18 + 6'(4 * (n % 3)), 16'($urandom()));
      if (n % 13 == 0) rd(6'h14, "R4 random input", v);
    end
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule